// File: doc/BRIEF.md
# Isochronous IN Stream Endpoint

This block is the device-side logic of one isochronous IN endpoint. It watches the decoded token fields coming from the receive path. Once a new frame has begun, it waits for an IN token that names its own endpoint number and for the moment the host is ready to take a response. It then raises a one-cycle data-request strobe and starts a packet toward the packet transmitter.

The packet length comes from a runtime length input. That input is captured when the request is taken and clamped to the endpoint's maximum packet size. Bytes come from a valid/ready producer stream. The transmitter's ready is handed straight back to the producer, so a byte moves only when the transmitter accepts it. The outgoing stream flags the first and the last byte. If the producer has nothing on a beat, the block inserts a zero byte and still counts that beat, because an isochronous packet cannot wait. Only one packet goes out per frame.

Top module: `iso_in_stream_ep`

## Requirements
- R1: After a synchronous reset the block is idle, and `data_req`, `tx_valid`, `tx_first`, `tx_last`, `tx_data` and `src_ready` are all 0.
- R2: `tok_new_frame` arms the endpoint for one packet. A request is honoured only while the endpoint is armed, and honouring it disarms the endpoint. `tok_new_frame` on its own starts nothing.
- R3: A request is honoured only when the block is idle and, in the same cycle, `tok_ep` equals `EP_NUM`, `tok_is_in` is 1 and `tok_rsp_ready` is 1.
- R4: `data_req` is high for exactly one cycle, in the cycle after the clock edge that honoured the request.
- R5: In the cycle after the `data_req` pulse, `tx_valid` is 1 and `tx_first` is 1. `tx_last` is 0 there unless the packet length is 1.
- R6: `src_ready` equals `tx_ready` while `tx_valid` is 1 and is 0 otherwise. While `tx_valid` is 1 and `src_valid` is 1, `tx_data` equals `src_data`.
- R7: A byte is consumed on each clock edge where `tx_valid` and `tx_ready` are both 1, so N bytes take N accepting cycles. While `tx_ready` is 0 the beat and its flags hold.
- R8: `tx_last` is 1 only on the N-th byte. The block is idle, with `tx_valid` 0, in the cycle after that byte is accepted.
- R9: The length is captured from `bytes_in_frame` when the request is honoured. Changes to `bytes_in_frame` during the packet have no effect on it.
- R10: A `bytes_in_frame` value above `MAX_PKT` (default 512) sends exactly `MAX_PKT` bytes.
- R11: A length of 0 still produces the `data_req` pulse. `tx_valid` then never rises and the block returns to idle.
- R12: Whenever `tx_valid` is 0, `tx_data`, `tx_first` and `tx_last` are 0.
- R13: A beat accepted while `src_valid` is 0 carries `tx_data` of 0 and counts toward the packet length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_ep | input | EP_W | Endpoint number of the current token |
| tok_is_in | input | 1 | Current token is an IN token |
| tok_new_frame | input | 1 | Start-of-frame indication |
| tok_rsp_ready | input | 1 | Host is ready for this endpoint's response |
| bytes_in_frame | input | BIF_W | Requested bytes per packet |
| src_data | input | DATA_W | Producer byte |
| src_valid | input | 1 | Producer byte valid |
| src_ready | output | 1 | Producer byte taken this cycle |
| tx_data | output | DATA_W | Byte to the transmitter |
| tx_valid | output | 1 | Packet beat present |
| tx_first | output | 1 | Beat is the first of the packet |
| tx_last | output | 1 | Beat is the last of the packet |
| tx_ready | input | 1 | Transmitter accepts the beat |
| data_req | output | 1 | One-cycle strobe when a request is taken |

## Verification
The bench targets the length boundaries: a single-byte packet, where first and last coincide; a zero length, where a design that entered the send state would emit a stray beat that never ends; and an oversize length, which a design without the clamp would run past the maximum. It stalls the transmitter in mid-packet and rewrites the length input while the packet is running. A counter that advanced on stalls, or that read the live length, would move `tx_last` off the expected byte. A second request in the same frame, a mismatched endpoint number and an OUT direction are all applied. A design that skipped the arming step or the token match would raise `data_req` for these. A starved producer beat is also applied: a design that stalled on it, or forwarded stale data, would show it on `tx_data`.

// File: rtl/iso_in_pkg.sv
package iso_in_pkg;
  typedef enum logic [1:0] {
    EP_IDLE = 2'd0,
    EP_REQ  = 2'd1,
    EP_SEND = 2'd2
  } ep_state_e;
endpackage

// File: rtl/iso_in_req_detect.sv
module iso_in_req_detect #(
  parameter int EP_W   = 4,
  parameter int EP_NUM = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [EP_W-1:0] tok_ep,
  input  logic            tok_is_in,
  input  logic            tok_rsp_ready,
  input  logic            tok_new_frame,
  input  logic            idle,
  output logic            take
);
  logic armed_q;
  logic hit;

  // token aimed at this endpoint, IN direction, response slot open
  assign hit  = (tok_ep == EP_W'(EP_NUM)) && tok_is_in && tok_rsp_ready;
  assign take = armed_q && hit && idle;

  // one packet per frame: a frame start re-arms, a taken request disarms
  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= tok_new_frame | (armed_q & ~take);
  end
endmodule

// File: rtl/iso_in_len_ctr.sv
module iso_in_len_ctr #(
  parameter int MAX_PKT = 512,
  parameter int BIF_W   = 16,
  parameter int LEN_W   = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [BIF_W-1:0] bif,
  input  logic             accept,
  output logic             len_zero,
  output logic             at_first,
  output logic             at_last
);
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_clamped;

  always_comb begin
    if (bif > BIF_W'(MAX_PKT)) len_clamped = LEN_W'(MAX_PKT);
    else                       len_clamped = bif[LEN_W-1:0];
  end

  assign len_zero = (len_q == '0);
  assign at_first = (cnt_q == '0);
  assign at_last  = (cnt_q == len_q - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      len_q <= len_clamped;
      cnt_q <= '0;
    end else if (accept) begin
      cnt_q <= at_last ? '0 : cnt_q + LEN_W'(1);
    end
  end
endmodule

// File: rtl/iso_in_ctrl.sv
module iso_in_ctrl
  import iso_in_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      take,
  input  logic      len_zero,
  input  logic      accept,
  input  logic      at_last,
  output ep_state_e state
);
  ep_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      EP_IDLE: if (take) state_d = EP_REQ;
      EP_REQ:  state_d = len_zero ? EP_IDLE : EP_SEND;
      EP_SEND: if (accept && at_last) state_d = EP_IDLE;
      default: state_d = EP_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= EP_IDLE;
    else     state <= state_d;
  end
endmodule

// File: rtl/iso_in_stream_ep.sv
module iso_in_stream_ep
  import iso_in_pkg::*;
#(
  parameter int EP_W    = 4,
  parameter int EP_NUM  = 1,
  parameter int DATA_W  = 8,
  parameter int MAX_PKT = 512,
  parameter int BIF_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [EP_W-1:0]   tok_ep,
  input  logic              tok_is_in,
  input  logic              tok_new_frame,
  input  logic              tok_rsp_ready,
  input  logic [BIF_W-1:0]  bytes_in_frame,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_valid,
  output logic              src_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_valid,
  output logic              tx_first,
  output logic              tx_last,
  input  logic              tx_ready,
  output logic              data_req
);
  localparam int LEN_W = $clog2(MAX_PKT + 1);

  ep_state_e state;
  logic take, len_zero, at_first, at_last, in_send, accept;

  assign in_send = (state == EP_SEND);
  assign accept  = in_send && tx_ready;

  iso_in_req_detect #(.EP_W(EP_W), .EP_NUM(EP_NUM)) i_detect (
    .clk(clk), .rst(rst), .tok_ep(tok_ep), .tok_is_in(tok_is_in),
    .tok_rsp_ready(tok_rsp_ready), .tok_new_frame(tok_new_frame),
    .idle(state == EP_IDLE), .take(take)
  );

  iso_in_len_ctr #(.MAX_PKT(MAX_PKT), .BIF_W(BIF_W), .LEN_W(LEN_W)) i_len (
    .clk(clk), .rst(rst), .load(take), .bif(bytes_in_frame), .accept(accept),
    .len_zero(len_zero), .at_first(at_first), .at_last(at_last)
  );

  iso_in_ctrl i_ctrl (
    .clk(clk), .rst(rst), .take(take), .len_zero(len_zero),
    .accept(accept), .at_last(at_last), .state(state)
  );

  assign data_req  = (state == EP_REQ);
  assign tx_valid  = in_send;
  assign tx_first  = in_send && at_first;
  assign tx_last   = in_send && at_last;
  assign src_ready = accept;
  // underrun: a starved beat goes out as zero and still counts
  assign tx_data   = (in_send && src_valid) ? src_data : '0;
endmodule

// File: rtl/iso_in_stream_ep_chk.sv
module iso_in_stream_ep_chk #(
  parameter int EP_W   = 4,
  parameter int EP_NUM = 1,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [EP_W-1:0]   tok_ep,
  input logic              tok_is_in,
  input logic              tok_rsp_ready,
  input logic              src_ready,
  input logic [DATA_W-1:0] tx_data,
  input logic              tx_valid,
  input logic              tx_first,
  input logic              tx_last,
  input logic              tx_ready,
  input logic              data_req
);
  AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    data_req |=> !data_req); // R4

  AST_REQ_NEEDS_TOKEN: assert property (@(posedge clk) disable iff (rst)
    $rose(data_req) |-> $past(tok_rsp_ready && tok_is_in && (tok_ep == EP_W'(EP_NUM)))); // R3

  AST_SEND_OPENS_FIRST: assert property (@(posedge clk) disable iff (rst)
    data_req |=> (!tx_valid || tx_first)); // R5

  AST_NO_PRODUCER_PULL_IDLE: assert property (@(posedge clk) disable iff (rst)
    !tx_valid |-> !src_ready); // R6

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_first) && $stable(tx_last))); // R7

  AST_FIRST_ONLY_ONCE: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && !tx_last) |=> (tx_valid && !tx_first)); // R7

  AST_LAST_ENDS_PACKET: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && tx_last) |=> !tx_valid); // R8

  AST_QUIET_WHEN_INVALID: assert property (@(posedge clk) disable iff (rst)
    !tx_valid |-> (tx_data == '0 && !tx_first && !tx_last)); // R12
endmodule

bind iso_in_stream_ep iso_in_stream_ep_chk #(.EP_W(EP_W), .EP_NUM(EP_NUM), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst(rst), .tok_ep(tok_ep), .tok_is_in(tok_is_in),
  .tok_rsp_ready(tok_rsp_ready), .src_ready(src_ready), .tx_data(tx_data),
  .tx_valid(tx_valid), .tx_first(tx_first), .tx_last(tx_last),
  .tx_ready(tx_ready), .data_req(data_req)
);

// File: tb/test_iso_in_stream_ep.sv
`timescale 1ns/1ps
module test_iso_in_stream_ep;
  localparam int EP_W = 4, EP_NUM = 1, DATA_W = 8, MAX_PKT = 512, BIF_W = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic [EP_W-1:0] tok_ep = '0;
  logic tok_is_in = 1'b0, tok_new_frame = 1'b0, tok_rsp_ready = 1'b0;
  logic [BIF_W-1:0] bytes_in_frame = '0;
  logic [DATA_W-1:0] src_data = '0;
  logic src_valid = 1'b0, tx_ready = 1'b0;
  logic src_ready, tx_valid, tx_first, tx_last, data_req;
  logic [DATA_W-1:0] tx_data;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  iso_in_stream_ep #(.EP_W(EP_W), .EP_NUM(EP_NUM), .DATA_W(DATA_W),
                     .MAX_PKT(MAX_PKT), .BIF_W(BIF_W)) i_iso_in_stream_ep (
    .clk(clk), .rst(rst), .tok_ep(tok_ep), .tok_is_in(tok_is_in),
    .tok_new_frame(tok_new_frame), .tok_rsp_ready(tok_rsp_ready),
    .bytes_in_frame(bytes_in_frame), .src_data(src_data), .src_valid(src_valid),
    .src_ready(src_ready), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_first(tx_first), .tx_last(tx_last), .tx_ready(tx_ready), .data_req(data_req)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 7 + 3) & 8'hFF);
  endfunction

  task automatic pulse_frame();
    @(negedge clk) tok_new_frame = 1'b1;
    @(negedge clk) tok_new_frame = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "data_req", data_req, 0);
    chk("R1", "tx_valid", tx_valid, 0);
    chk("R1", "tx_first|tx_last", tx_first | tx_last, 0);
    chk("R1", "tx_data", tx_data, 0);
    chk("R1", "src_ready", src_ready, 0);
  endtask

  // frame start with no request: nothing happens
  task automatic t_frame_only();
    int seen = 0;
    pulse_frame();
    tok_ep = EP_W'(EP_NUM); tok_is_in = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      seen += int'(data_req) + int'(tx_valid);
    end
    chk("R2", "activity after frame start alone", seen, 0);
  endtask

  // armed, but token mismatches on number or direction
  task automatic t_wrong_token();
    int seen = 0;
    pulse_frame();
    tok_ep = EP_W'(EP_NUM + 1); tok_is_in = 1'b1; tok_rsp_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      seen += int'(data_req);
    end
    chk("R3", "data_req on other endpoint", seen, 0);
    tok_ep = EP_W'(EP_NUM); tok_is_in = 1'b0;
    seen = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      seen += int'(data_req);
    end
    chk("R3", "data_req on OUT direction", seen, 0);
    tok_rsp_ready = 1'b0;
  endtask

  // second request inside the same frame
  task automatic t_same_frame();
    int seen = 0;
    tok_ep = EP_W'(EP_NUM); tok_is_in = 1'b1; tok_rsp_ready = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      seen += int'(data_req) + int'(tx_valid);
    end
    tok_rsp_ready = 1'b0;
    chk("R2", "second request in one frame", seen, 0);
  endtask

  task automatic run_packet(input string tag, input int len, input int stall_every,
                            input int gap_idx, input int new_bif);
    int n = (len > MAX_PKT) ? MAX_PKT : len;
    pulse_frame();
    tok_ep = EP_W'(EP_NUM); tok_is_in = 1'b1; tok_rsp_ready = 1'b1;
    bytes_in_frame = BIF_W'(len);
    @(negedge clk);
    tok_rsp_ready = 1'b0;
    chk("R4", {tag, " data_req after request"}, data_req, 1);
    chk("R12", {tag, " tx_valid during request"}, tx_valid, 0);
    @(negedge clk);
    chk("R4", {tag, " data_req width"}, data_req, 0);
    if (n == 0) begin
      chk("R11", {tag, " zero length tx_valid"}, tx_valid, 0);
      @(negedge clk);
      chk("R11", {tag, " zero length stays quiet"}, tx_valid, 0);
      return;
    end
    chk("R5", {tag, " tx_valid"}, tx_valid, 1);
    chk("R5", {tag, " tx_first"}, tx_first, 1);
    chk("R5", {tag, " tx_last"}, tx_last, int'(n == 1));
    bytes_in_frame = BIF_W'(new_bif);           // R9: must not matter now
    for (int i = 0; i < n; i++) begin
      if (stall_every > 0 && (i % stall_every) == 1) begin
        tx_ready = 1'b0; src_valid = 1'b1; src_data = pat(i);
        #1;
        chk("R6", {tag, " src_ready while stalled"}, src_ready, 0);
        @(negedge clk);
        chk("R7", {tag, " beat held on stall"}, tx_valid, 1);
        chk("R7", {tag, " last held on stall"}, tx_last, int'(i == n - 1));
      end
      tx_ready = 1'b1;
      src_valid = (i != gap_idx);
      src_data = pat(i);
      #1;
      chk("R6", {tag, " src_ready"}, src_ready, 1);
      if (i == gap_idx) chk("R13", {tag, " underrun byte"}, tx_data, 0);
      else              chk("R6", {tag, " tx_data"}, tx_data, pat(i));
      chk("R7", {tag, " tx_first"}, tx_first, int'(i == 0));
      chk((len > MAX_PKT) ? "R10" : "R8", {tag, " tx_last"}, tx_last, int'(i == n - 1));
      chk("R9", {tag, " still valid"}, tx_valid, 1);
      @(negedge clk);
    end
    tx_ready = 1'b0; src_valid = 1'b0; src_data = '0;
    #1;
    chk("R8", {tag, " idle after last"}, tx_valid, 0);
    chk("R12", {tag, " data zero when idle"}, tx_data, 0);
    chk("R12", {tag, " flags zero when idle"}, tx_first | tx_last, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_frame_only();
    t_wrong_token();
    run_packet("len8", 8, 3, 2, 3);
    t_same_frame();
    run_packet("len1", 1, 0, -1, 50);
    run_packet("len512", 512, 0, -1, 4);
    run_packet("len600", 600, 97, -1, 600);
    run_packet("len0", 0, 0, -1, 0);
    run_packet("len5", 5, 2, 4, 1);
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule